// File: doc/BRIEF.md
# Bus Cycle Phase Tracker

This block works out which of the eight half-clock states (S0 to S7) an asynchronous processor bus cycle on an expansion slot is in. It watches three slot signals: the slot's 7 MHz bus clock, a companion clock that lags it by a quarter period, and the active-low address strobe. A faster system clock samples all three through synchronizer chains and turns them into single-cycle edge pulses. The strobe is only looked at when the companion clock falls. That instant lies in the middle of a state and never inside S2, where the strobe is allowed to move. The first sample that finds the strobe low after a high sample marks the middle of S3, and the tracker locks there.

Once locked, the tracker steps one state on every edge of the bus clock. It tells a DRAM controller when the S4 to S7 window is open. It also drives the termination lines a slave card needs. In the normal mode it pulls the slot ready line low to stretch the cycle while the card asks for more time. In the handshake-takeover mode it pulls the override line low and generates the data acknowledge itself. Only cycles whose address lies in a single configurable range are tracked.

Top module: `bus_phase_tracker`

## Requirements
- R1: While reset is held and after it is released, with no strobe activity, `phase_valid` and `dram_win` are 0, `phase` is 0, and `rdy_hold_n`, `ovr_n` and `ack_n` are 1.
- R2: The strobe is sampled only at falling edges of `bus_clkq`. A low pulse on `strobe_n` that starts and ends between two such edges leaves the tracker idle.
- R3: When a sampled strobe of 1 is followed by a sampled strobe of 0 and the address is in range, the tracker becomes valid with `phase` = 3.
- R4: Once valid, `phase` advances by one on every rising and falling edge of `bus_clk7`. After 7, the next edge (a rising one) returns the tracker to idle. A cycle with no waits is therefore valid for S3 to S7 and spans four bus clock periods from S0.
- R5: In S4, `phase` stays at 4 while `card_wait` is high. It moves to 5 only at a falling `bus_clk7` edge with `card_wait` low, so each wait adds one full bus clock period.
- R6: `dram_win` is 1 exactly when the tracker is valid with `phase` from 4 to 7. That is from the rising edge that starts S4 up to the rising edge that ends S7.
- R7: Only addresses from 0x200000 to 0x9FFFFF inclusive lock the tracker. 0x1FFFFF and 0xA00000 do not.
- R8: A sampled strobe of 1 while valid and `phase` is not 7 returns the tracker to idle at once. This is an aborted cycle.
- R9: With `own_handshake` = 0, `rdy_hold_n` is 0 while valid and `card_wait` is high, and `ovr_n` and `ack_n` stay 1.
- R10: With `own_handshake` = 1, `ovr_n` is 0 while valid. `ack_n` is 0 while valid, `phase` is 4 or more and `card_wait` is low. `rdy_hold_n` stays 1.
- R11: While not valid, `phase` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock, much faster than the bus clock |
| rst | input | 1 | synchronous active-high reset |
| bus_clk7 | input | 1 | slot 7 MHz bus clock, asynchronous |
| bus_clkq | input | 1 | quadrature companion clock, lags bus_clk7 by a quarter period |
| strobe_n | input | 1 | active-low address strobe, asynchronous |
| bus_addr | input | ADDR_W | bus address, stable by mid S3 |
| card_wait | input | 1 | card requests wait states (system clock domain) |
| own_handshake | input | 1 | 1 selects override and self-generated acknowledge |
| phase | output | 3 | current state index, 0 when not valid |
| phase_valid | output | 1 | tracker is locked to a cycle |
| dram_win | output | 1 | DRAM access window S4 to S7 |
| rdy_hold_n | output | 1 | active-low ready drive that stretches the cycle |
| ovr_n | output | 1 | active-low override drive |
| ack_n | output | 1 | active-low data acknowledge drive |

## Verification
Every output is a register that sits four system clock edges after a bus-side input change: two synchronizer stages, the state update, then the output stage. `card_wait` reaches the outputs one edge later. The bench moves the bus clocks in quarter-period steps of six system clocks. It compares every output once per quarter, just before the next step, so each result has settled. The expected state in each quarter is computed from the quarter index, the number of waits and the strobe pattern.

// File: rtl/bpt_pkg.sv
package bpt_pkg;
  typedef logic [2:0] phase_t;
  localparam phase_t PH_LOCK = 3'd3;
  localparam phase_t PH_WIN  = 3'd4;
  localparam phase_t PH_LAST = 3'd7;
endpackage

// File: rtl/bpt_bit_sync.sv
module bpt_bit_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  localparam int LAST = STAGES - 1;
  logic [LAST:0] chain;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[0] <= RST_VAL;
        else     chain[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= RST_VAL;
        else     chain[i] <= chain[i-1];
      end
    end
  end

  assign q = chain[LAST];
endmodule

// File: rtl/bpt_edge_det.sv
module bpt_edge_det #(
  parameter int STAGES  = 2,
  parameter bit FALLING = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic pulse
);
  logic lvl, lvl_d;

  bpt_bit_sync #(.STAGES(STAGES), .RST_VAL(1'b0)) u_sync (
    .clk(clk), .rst(rst), .d(async_in), .q(lvl)
  );

  always_ff @(posedge clk) begin
    if (rst) lvl_d <= 1'b0;
    else     lvl_d <= lvl;
  end

  if (FALLING) begin : g_fall
    assign pulse = lvl_d & ~lvl;
  end else begin : g_rise
    assign pulse = lvl & ~lvl_d;
  end
endmodule

// File: rtl/bpt_phase_track.sv
module bpt_phase_track
  import bpt_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   c7_rise,
  input  logic   c7_fall,
  input  logic   cq_fall,
  input  logic   strobe_s,
  input  logic   addr_hit,
  input  logic   wait_req,
  output logic   locked,
  output phase_t cur
);
  logic strobe_prev;
  logic seen_assert, seen_negate, c7_any, hold_s4;

  assign seen_assert = cq_fall && strobe_prev && !strobe_s;
  assign seen_negate = cq_fall && strobe_s;
  assign c7_any      = c7_rise || c7_fall;
  assign hold_s4     = (cur == PH_WIN) && (c7_rise || wait_req);

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_prev <= 1'b1;
      locked      <= 1'b0;
      cur         <= '0;
    end else begin
      if (cq_fall) strobe_prev <= strobe_s;
      if (seen_assert && addr_hit) begin
        locked <= 1'b1;
        cur    <= PH_LOCK;
      end else if (seen_negate && locked && cur != PH_LAST) begin
        locked <= 1'b0;
        cur    <= '0;
      end else if (c7_any && locked) begin
        if (cur == PH_LAST) begin
          locked <= 1'b0;
          cur    <= '0;
        end else if (!hold_s4) begin
          cur <= cur + 3'd1;
        end
      end
    end
  end
endmodule

// File: rtl/bpt_term_ctrl.sv
module bpt_term_ctrl
  import bpt_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   locked,
  input  phase_t cur,
  input  logic   wait_req,
  input  logic   own_mode,
  output phase_t phase_o,
  output logic   valid_o,
  output logic   win_o,
  output logic   hold_n_o,
  output logic   ovr_n_o,
  output logic   ack_n_o
);
  logic in_win;
  assign in_win = locked && (cur >= PH_WIN);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_o  <= '0;
      valid_o  <= 1'b0;
      win_o    <= 1'b0;
      hold_n_o <= 1'b1;
      ovr_n_o  <= 1'b1;
      ack_n_o  <= 1'b1;
    end else begin
      phase_o  <= locked ? cur : '0;
      valid_o  <= locked;
      win_o    <= in_win;
      hold_n_o <= !(!own_mode && locked && wait_req);
      ovr_n_o  <= !(own_mode && locked);
      ack_n_o  <= !(own_mode && in_win && !wait_req);
    end
  end
endmodule

// File: rtl/bus_phase_tracker.sv
module bus_phase_tracker
  import bpt_pkg::*;
#(
  parameter int              ADDR_W      = 24,
  parameter logic [ADDR_W-1:0] RANGE_LO  = 24'h200000,
  parameter logic [ADDR_W-1:0] RANGE_HI  = 24'h9FFFFF,
  parameter int              SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_clk7,
  input  logic              bus_clkq,
  input  logic              strobe_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              card_wait,
  input  logic              own_handshake,
  output logic [2:0]        phase,
  output logic              phase_valid,
  output logic              dram_win,
  output logic              rdy_hold_n,
  output logic              ovr_n,
  output logic              ack_n
);
  logic c7_rise, c7_fall, cq_fall, strobe_s, addr_hit, locked;
  phase_t cur;

  bpt_edge_det #(.STAGES(SYNC_STAGES), .FALLING(1'b0)) u_c7_rise (
    .clk(clk), .rst(rst), .async_in(bus_clk7), .pulse(c7_rise)
  );
  bpt_edge_det #(.STAGES(SYNC_STAGES), .FALLING(1'b1)) u_c7_fall (
    .clk(clk), .rst(rst), .async_in(bus_clk7), .pulse(c7_fall)
  );
  bpt_edge_det #(.STAGES(SYNC_STAGES), .FALLING(1'b1)) u_cq_fall (
    .clk(clk), .rst(rst), .async_in(bus_clkq), .pulse(cq_fall)
  );
  bpt_bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_strobe (
    .clk(clk), .rst(rst), .d(strobe_n), .q(strobe_s)
  );

  assign addr_hit = (bus_addr >= RANGE_LO) && (bus_addr <= RANGE_HI);

  bpt_phase_track u_track (
    .clk(clk), .rst(rst), .c7_rise(c7_rise), .c7_fall(c7_fall),
    .cq_fall(cq_fall), .strobe_s(strobe_s), .addr_hit(addr_hit),
    .wait_req(card_wait), .locked(locked), .cur(cur)
  );

  bpt_term_ctrl u_term (
    .clk(clk), .rst(rst), .locked(locked), .cur(cur),
    .wait_req(card_wait), .own_mode(own_handshake),
    .phase_o(phase), .valid_o(phase_valid), .win_o(dram_win),
    .hold_n_o(rdy_hold_n), .ovr_n_o(ovr_n), .ack_n_o(ack_n)
  );
endmodule

// File: rtl/bpt_checker.sv
module bpt_checker (
  input logic       clk,
  input logic       rst,
  input logic [2:0] phase,
  input logic       phase_valid,
  input logic       dram_win,
  input logic       rdy_hold_n,
  input logic       ovr_n,
  input logic       ack_n
);
  assert_idle_phase_zero_R11: assert property (@(posedge clk) disable iff (rst)
    !phase_valid |-> phase == 3'd0);
  assert_dram_in_window_R6: assert property (@(posedge clk) disable iff (rst)
    dram_win |-> phase_valid && phase >= 3'd4);
  assert_lock_at_s3_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(phase_valid) |-> phase == 3'd3);
  assert_single_step_R4: assert property (@(posedge clk) disable iff (rst)
    (phase_valid && $past(phase_valid) && phase != $past(phase))
      |-> phase == $past(phase) + 3'd1);
  assert_ovr_only_valid_R10: assert property (@(posedge clk) disable iff (rst)
    !ovr_n |-> phase_valid);
  assert_ack_with_ovr_R10: assert property (@(posedge clk) disable iff (rst)
    !ack_n |-> !ovr_n && dram_win);
  assert_hold_normal_mode_R9: assert property (@(posedge clk) disable iff (rst)
    !rdy_hold_n |-> ovr_n && phase_valid);
endmodule

bind bus_phase_tracker bpt_checker u_bpt_checker (
  .clk(clk), .rst(rst), .phase(phase), .phase_valid(phase_valid),
  .dram_win(dram_win), .rdy_hold_n(rdy_hold_n), .ovr_n(ovr_n), .ack_n(ack_n)
);

// File: tb/tb_bus_phase_tracker.sv
module tb_bus_phase_tracker;
  localparam int QCLK = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_clk7 = 1'b1, bus_clkq = 1'b0, strobe_n = 1'b1;
  logic [23:0] bus_addr = '0;
  logic        card_wait = 1'b0, own_handshake = 1'b0;
  logic [2:0]  phase;
  logic        phase_valid, dram_win, rdy_hold_n, ovr_n, ack_n;

  int n_chk = 0, n_fail = 0, q = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bus_phase_tracker dut (
    .clk(clk), .rst(rst), .bus_clk7(bus_clk7), .bus_clkq(bus_clkq),
    .strobe_n(strobe_n), .bus_addr(bus_addr), .card_wait(card_wait),
    .own_handshake(own_handshake), .phase(phase), .phase_valid(phase_valid),
    .dram_win(dram_win), .rdy_hold_n(rdy_hold_n), .ovr_n(ovr_n), .ack_n(ack_n)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d (quarter %0d)", tag, what, act, exp, q);
    end
  endtask

  task automatic quarter(input int r, input int sc, input int w, input bit own, input bit hit);
    int m;
    bit slow, ev, cw;
    int ep;
    string tp;
    m = q % 4;
    case (sc)
      0: slow = (r >= 5) && (r < 14 + 4*w);
      1: slow = (r >= 5) && (r < 9);
      default: slow = (r >= 4) && (r < 6);
    endcase
    cw = (w > 0) && (r < 9 + 4*w);
    bus_clk7 = (m < 2);
    bus_clkq = (m == 1) || (m == 2);
    strobe_n = !slow;
    card_wait = cw;
    own_handshake = own;
    repeat (QCLK) @(negedge clk);
    ev = 1'b0; ep = 0;
    if (hit && sc == 0) begin
      ev = (r >= 7) && (r < 16 + 4*w);
      ep = (r < 8) ? 3 : (r < 10 + 4*w) ? 4 : 5 + (r - 10 - 4*w) / 2;
    end else if (hit && sc == 1) begin
      ev = (r >= 7) && (r < 11);
      ep = r / 2;
    end
    if (!ev) ep = 0;
    if (!hit) tp = "R7";
    else if (sc == 2) tp = "R2";
    else if (sc == 1) tp = "R8";
    else if (r == 7) tp = "R3";
    else if (w > 0) tp = "R5";
    else tp = "R4";
    chk(tp, "phase_valid", int'(phase_valid), int'(ev));
    chk(ev ? tp : "R11", "phase", int'(phase), ep);
    chk("R6", "dram_win", int'(dram_win), int'(ev && ep >= 4));
    chk(own ? "R10" : "R9", "rdy_hold_n", int'(rdy_hold_n), int'(!(!own && ev && cw)));
    chk(own ? "R10" : "R9", "ovr_n", int'(ovr_n), int'(!(own && ev)));
    chk(own ? "R10" : "R9", "ack_n", int'(ack_n), int'(!(own && ev && ep >= 4 && !cw)));
    q++;
  endtask

  task automatic run_cycle(input int sc, input int w, input bit own, input logic [23:0] a);
    bit hit;
    bus_addr = a;
    hit = (a >= 24'h200000) && (a <= 24'h9FFFFF);
    for (int r = 0; r < 20 + 4*w; r++) quarter(r, sc, w, own, hit);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk("R1", "phase_valid in reset", int'(phase_valid), 0);
    chk("R1", "ack_n in reset", int'(ack_n), 1);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1", "phase_valid", int'(phase_valid), 0);
    chk("R1", "phase", int'(phase), 0);
    chk("R1", "dram_win", int'(dram_win), 0);
    chk("R1", "hold/ovr/ack", int'({rdy_hold_n, ovr_n, ack_n}), 7);
    for (int own = 0; own < 2; own++)
      for (int w = 0; w < 4; w++) run_cycle(0, w, own[0], 24'h400000);
    run_cycle(0, 0, 1'b0, 24'h1FFFFF);
    run_cycle(0, 0, 1'b0, 24'h200000);
    run_cycle(0, 0, 1'b1, 24'h9FFFFF);
    run_cycle(0, 0, 1'b1, 24'hA00000);
    run_cycle(1, 0, 1'b0, 24'h300000);
    run_cycle(1, 0, 1'b1, 24'h300000);
    run_cycle(2, 0, 1'b0, 24'h300000);
    run_cycle(2, 1, 1'b1, 24'h300000);
    run_cycle(0, 2, 1'b0, 24'h800000);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog run did not complete actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule